// File: doc/BRIEF.md
# Program/Erase Engine for a Byte-Wide Non-Volatile Array

This block performs the two write-type operations of a byte-wide non-volatile store: single-byte programming and whole-array erase. A command decoder upstream turns host command sequences into one-cycle start pulses with an address and a data byte. The engine times each operation with a cycle counter, updates the internal byte array, and releases its busy flag when it is done. While it is busy, host reads return a status byte instead of array contents, so software can poll for completion.

Programming can only clear bits. The stored byte becomes the old byte ANDed with the write data. Erase fills bytes with 0xFF. A protection flag, sampled when a request is accepted, shields the low boot region. When the flag is set, erase sweeps past that region and program requests aimed at it leave the array alone.

The address width, boot region size and both operation durations are parameters. With `ADDR_W=18` and `BOOT_BYTES=8192` the engine covers a 256 KiB array with an 8 KiB boot region. The defaults are smaller so that elaboration stays light.

Top module: `nvm_write_engine`

## Requirements
- R1: A program request makes the byte at its address equal to the old byte ANDed with the request data. Bits that are already 0 stay 0.
- R2: An erase accepted while `boot_lock` is 0 sets every byte of the array to 0xFF.
- R3: An erase accepted while `boot_lock` is 1 sets every byte at address `BOOT_BYTES` and above to 0xFF. It leaves the bytes below `BOOT_BYTES` unchanged.
- R4: A program request accepted while `boot_lock` is 1 with an address below `BOOT_BYTES` leaves the array unchanged but still runs its full timed duration. The same request at address `BOOT_BYTES` or above programs normally.
- R5: After reset `busy` is 0 and `rd_data` is 0. An accepted request raises `busy` in the next cycle. `busy` then stays high for exactly `PROG_CYCLES` cycles for a program and `ERASE_CYCLES` cycles for an erase, after which the engine is idle again without any further input.
- R6: Requests that arrive while `busy` is 1 are ignored. When `erase_req` and `prog_req` arrive together in an idle cycle, only the erase is performed.
- R7: A read strobed during a program returns, in bit 7, the complement of bit 7 of the data being programmed.
- R8: A read strobed during an erase returns 0 in bit 7.
- R9: During an operation, bits 5..0 of each read are 0. Bit 6 is 0 on the first read after the operation starts and inverts on every further read until the operation ends.
- R10: A read strobed while idle returns the array byte at `rd_addr` one cycle after `rd_strobe`. `rd_data` holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_req | input | 1 | One-cycle request to program one byte |
| erase_req | input | 1 | One-cycle request to erase the whole array |
| req_addr | input | ADDR_W | Byte address of a program request |
| req_data | input | 8 | Data of a program request |
| boot_lock | input | 1 | Boot region protection, sampled when a request is accepted |
| rd_strobe | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Registered read result: array byte when idle, status byte when busy |
| busy | output | 1 | High while an operation is in progress |

## Verification
The main function is tried with program data that has bit 7 set and with data that has it clear, so the polled bit 7 shows both complement values. Repeated programs of one address show the AND behaviour: one that clears more bits and one that tries to set them again.

Program requests are aimed at the last protected address, the first unprotected address and a deep boot address, each with and without protection. This separates an off-by-one in the region compare from a missing lock check. Erases run both locked and unlocked, and are followed by reads on both sides of the region edge.

Overlapping and simultaneous requests separate request filtering from priority. Every operation also checks that the status toggle restarts at 0.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

    localparam int BYTE_W     = 8;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [1:0] {
        PE_IDLE  = 2'd0,
        PE_PROG  = 2'd1,
        PE_ERASE = 2'd2
    } pe_state_e;

endpackage

// File: rtl/nvm_pe_guard.sv
module nvm_pe_guard #(
    parameter int ADDR_W     = 11,
    parameter int BOOT_BYTES = 256
) (
    input  logic              lock,
    input  logic [ADDR_W-1:0] addr,
    output logic              shielded
);
    localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_BYTES);

    always_comb begin
        shielded = lock && ({1'b0, addr} < BOOT_LIM);
    end
endmodule

// File: rtl/nvm_pe_array.sv
module nvm_pe_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_fill) begin
                cells[wr_addr] <= 8'hFF;
            end else begin
                cells[wr_addr] <= cells[wr_addr] & wr_data;
            end
        end
    end

    always_comb begin
        rd_data = cells[rd_addr];
    end
endmodule

// File: rtl/nvm_pe_rdmux.sv
module nvm_pe_rdmux
    import nvm_pe_pkg::*;
(
    input  logic        busy,
    input  logic        erasing,
    input  logic        poll_src,
    input  logic        toggle,
    input  logic [7:0]  arr_data,
    output logic [7:0]  out_data
);
    always_comb begin
        if (busy) begin
            out_data             = '0;
            out_data[POLL_BIT]   = erasing ? 1'b0 : ~poll_src;
            out_data[TOGGLE_BIT] = toggle;
        end else begin
            out_data = arr_data;
        end
    end
endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine
    import nvm_pe_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int BOOT_BYTES   = 256,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              boot_lock,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0]  PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]  ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = '1;

    typedef struct packed {
        pe_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              lock;
        logic              blocked;
        logic [ADDR_W-1:0] sweep;
        logic              sweep_done;
        logic              toggle;
        logic [7:0]        rd_data;
    } regs_t;

    regs_t r_q, r_d;

    logic              req_shielded;
    logic              sweep_shielded;
    logic              wr_en;
    logic              wr_fill;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        arr_rd;
    logic [7:0]        mux_out;
    logic              erasing;
    logic              op_bit7;

    assign busy    = (r_q.state != PE_IDLE);
    assign erasing = (r_q.state == PE_ERASE);
    assign op_bit7 = r_q.data[POLL_BIT];
    assign rd_data = r_q.rd_data;

    nvm_pe_guard #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES)) i_req_guard (
        .lock     (boot_lock),
        .addr     (req_addr),
        .shielded (req_shielded)
    );

    nvm_pe_guard #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES)) i_sweep_guard (
        .lock     (r_q.lock),
        .addr     (r_q.sweep),
        .shielded (sweep_shielded)
    );

    nvm_pe_array #(.ADDR_W(ADDR_W)) i_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_fill (wr_fill),
        .wr_addr (wr_addr),
        .wr_data (r_q.data),
        .rd_addr (rd_addr),
        .rd_data (arr_rd)
    );

    nvm_pe_rdmux i_rdmux (
        .busy     (busy),
        .erasing  (erasing),
        .poll_src (op_bit7),
        .toggle   (r_q.toggle),
        .arr_data (arr_rd),
        .out_data (mux_out)
    );

    always_comb begin
        r_d     = r_q;
        wr_en   = 1'b0;
        wr_fill = 1'b0;
        wr_addr = r_q.addr;

        unique case (r_q.state)
            PE_IDLE: begin
                if (erase_req) begin
                    r_d.state      = PE_ERASE;
                    r_d.cnt        = ERASE_LOAD;
                    r_d.lock       = boot_lock;
                    r_d.sweep      = '0;
                    r_d.sweep_done = 1'b0;
                    r_d.toggle     = 1'b0;
                end else if (prog_req) begin
                    r_d.state   = PE_PROG;
                    r_d.cnt     = PROG_LOAD;
                    r_d.addr    = req_addr;
                    r_d.data    = req_data;
                    r_d.blocked = req_shielded;
                    r_d.toggle  = 1'b0;
                end
            end
            PE_PROG: begin
                if (r_q.cnt == '0) begin
                    wr_en     = !r_q.blocked;
                    r_d.state = PE_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            PE_ERASE: begin
                if (!r_q.sweep_done) begin
                    wr_en     = !sweep_shielded;
                    wr_fill   = 1'b1;
                    wr_addr   = r_q.sweep;
                    r_d.sweep = r_q.sweep + 1'b1;
                    if (r_q.sweep == LAST_ADDR) begin
                        r_d.sweep_done = 1'b1;
                    end
                end
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
                if ((r_q.cnt == '0) && r_q.sweep_done) begin
                    r_d.state = PE_IDLE;
                end
            end
            default: begin
                r_d.state = PE_IDLE;
            end
        endcase

        if (rd_strobe) begin
            r_d.rd_data = mux_out;
            if (busy) begin
                r_d.toggle = ~r_q.toggle;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/nvm_pe_checker.sv
module nvm_pe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_req,
    input logic       erase_req,
    input logic       rd_strobe,
    input logic       busy,
    input logic [7:0] rd_data,
    input logic       erasing,
    input logic       op_bit7
);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (prog_req || erase_req)) |=> busy);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // R9
    status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (rd_data[5:0] == 6'd0));

    // R8
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe && erasing) |=> !rd_data[7]);

    // R7
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe && !erasing) |=> (rd_data[7] == !$past(op_bit7)));
endmodule

bind nvm_write_engine nvm_pe_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_req  (prog_req),
    .erase_req (erase_req),
    .rd_strobe (rd_strobe),
    .busy      (busy),
    .rd_data   (rd_data),
    .erasing   (erasing),
    .op_bit7   (op_bit7)
);

// File: tb/test_nvm_write_engine.sv
module test_nvm_write_engine;
    localparam int CLK_PERIOD   = 10;
    localparam int ADDR_W       = 11;
    localparam int BOOT_BYTES   = 256;
    localparam int PROG_CYCLES  = 20;
    localparam int ERASE_CYCLES = 4000;
    localparam int WATCHDOG     = 150000;

    // vector: {kind[3:0] (0 program, 1 erase), lock[3:0], addr[11:0], data[7:0], chk_addr[11:0], expect[7:0]}
    localparam int NV = 11;
    localparam logic [47:0] VECS [NV] = '{
        {4'd1, 4'd0, 12'h000, 8'h00, 12'h000, 8'hFF},  // R2 unlocked erase
        {4'd0, 4'd0, 12'h005, 8'hA5, 12'h005, 8'hA5},  // R1 program erased byte
        {4'd0, 4'd0, 12'h005, 8'h3C, 12'h005, 8'h24},  // R1 AND with old byte
        {4'd0, 4'd0, 12'h400, 8'h0F, 12'h400, 8'h0F},  // R1 bit 7 clear
        {4'd0, 4'd1, 12'h010, 8'h5A, 12'h010, 8'hFF},  // R4 shielded deep boot
        {4'd0, 4'd1, 12'h100, 8'h77, 12'h100, 8'h77},  // R4 first unshielded
        {4'd0, 4'd1, 12'h0FF, 8'h11, 12'h0FF, 8'hFF},  // R4 last shielded
        {4'd1, 4'd1, 12'h000, 8'h00, 12'h005, 8'h24},  // R3 boot kept
        {4'd0, 4'd0, 12'h7FF, 8'h81, 12'h400, 8'hFF},  // R3 main erased
        {4'd0, 4'd0, 12'h7FF, 8'hFF, 12'h7FF, 8'h81},  // R1 cannot set bits
        {4'd1, 4'd0, 12'h000, 8'h00, 12'h005, 8'hFF}   // R2 boot erased unlocked
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_req = 1'b0;
    logic              erase_req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = '0;
    logic              boot_lock = 1'b0;
    logic              rd_strobe = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_write_engine #(
        .ADDR_W       (ADDR_W),
        .BOOT_BYTES   (BOOT_BYTES),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) i_nvm_write_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .boot_lock (boot_lock),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fails = n_fails + 1;
            $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr   = a;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        v = rd_data;
    endtask

    // Starts an operation, polls status on the first three busy cycles,
    // optionally injects requests mid-operation, and counts busy cycles.
    task automatic do_op(input logic p, input logic e, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input logic lk, input logic as_erase,
                         input logic inject, input logic [ADDR_W-1:0] inj_addr);
        int n;
        logic tog;
        logic [7:0] exp_s;
        n   = 0;
        tog = 1'b0;
        @(negedge clk);
        prog_req  = p;
        erase_req = e;
        req_addr  = a;
        req_data  = d;
        boot_lock = lk;
        rd_addr   = a;
        for (int k = 1; k < 20000; k++) begin
            @(negedge clk);
            prog_req  = 1'b0;
            erase_req = 1'b0;
            if (k >= 2 && k <= 4) begin
                exp_s    = 8'h00;
                exp_s[7] = as_erase ? 1'b0 : ~d[7];
                exp_s[6] = tog;
                if (as_erase) check("R8 R9 erase status", rd_data, exp_s);
                else          check("R7 R9 program status", rd_data, exp_s);
                tog = ~tog;
            end
            if (inject && k == 5) begin
                prog_req  = 1'b1;
                erase_req = 1'b1;
                req_addr  = inj_addr;
                req_data  = 8'h00;
            end
            rd_strobe = (k <= 3);
            if (!busy) break;
            n++;
        end
        rd_strobe = 1'b0;
        check("R5 busy length", n, as_erase ? ERASE_CYCLES : PROG_CYCLES);
    endtask

    initial begin
        logic [7:0] v;
        logic [47:0] vec;
        repeat (3) @(negedge clk);
        check("R5 reset busy", busy, 0);
        check("R5 reset rd_data", rd_data, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec = VECS[i];
            do_op(vec[44] == 1'b0, vec[44], vec[38:28], vec[27:20], vec[40], vec[44],
                  1'b0, '0);
            read_byte(vec[18:8], v);
            check("R1 R2 R3 R4 readback", v, vec[7:0]);
        end

        // R6: requests during an active program are dropped
        do_op(1'b1, 1'b0, 11'h300, 8'h00, 1'b0, 1'b0, 1'b1, 11'h301);
        read_byte(11'h300, v);
        check("R6 programmed target", v, 8'h00);
        read_byte(11'h301, v);
        check("R6 injected program ignored", v, 8'hFF);

        // R6: simultaneous requests, erase wins
        do_op(1'b1, 1'b1, 11'h302, 8'h00, 1'b0, 1'b1, 1'b0, '0);
        read_byte(11'h300, v);
        check("R6 erase performed", v, 8'hFF);
        read_byte(11'h302, v);
        check("R6 program dropped", v, 8'hFF);

        // R10: idle read timing and hold
        do_op(1'b1, 1'b0, 11'h006, 8'h42, 1'b0, 1'b0, 1'b0, '0);
        read_byte(11'h006, v);
        check("R10 idle read", v, 8'h42);
        @(negedge clk);
        rd_addr = 11'h007;
        @(negedge clk);
        check("R10 hold without strobe", rd_data, 8'h42);
        read_byte(11'h007, v);
        check("R10 read neighbour", v, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule